// File: doc/BRIEF.md
# Flash Self-Programming Controller

This block lets a processor read its own flash program memory and erase it in 32-word blocks, using a small set of byte-wide special-function registers. The processor loads a 16-bit word address into two address registers. It then writes the control register. A read returns the addressed word as a low byte and a high byte in two data registers. An erase wipes the aligned block that holds the address, leaving every word all ones. An erase is only accepted after the two-value unlock pair has been written to the key register.

The block tells the processor how to treat its own pipeline. A read or an erase command marks the next two instruction slots as ignored. An erase then halts the processor for the whole erase time, while the clock keeps running. A behavioural array model stands in for the flash. It has a synchronous read port, one write per cycle, and a parameter that sets the erase time in clock cycles.

Top module: `flash_selfprog`

## Requirements
- R1: After reset, every register reads zero, and `cpu_ignore` and `cpu_stall` are low. Register offsets: 0 address low, 1 address high, 2 data low, 3 data high, 4 control, 5 key. Unmapped offsets read zero.
- R2: Control bits are: 0 read-go, 1 erase-go, 2 write-enable, 3 erase-select, 4 write-error, 7 program-select. A control write with read-go and program-select set (0x81) raises `cpu_ignore` for exactly the two following cycles. From the third cycle, data low holds bits 7:0 of the word at the low log2(DEPTH) address bits, data high holds the remaining upper bits zero-extended, and read-go reads 0. The array model powers up with word i equal to (i*29+7) mod 2^DATA_W.
- R3: The data registers keep their value until the next read completes or the processor writes them. A processor write to either data register is read back as written.
- R4: A control write with read-go set and program-select clear starts nothing. `cpu_ignore` stays low, read-go reads 0 and the data registers are unchanged.
- R5: The key register is armed by a write of 0x55 followed by a write of 0xAA. No other register access may fall between them, but idle cycles may.
- R6: A control write with erase-go set is ignored unless the key is armed. Failed cases include a wrong value, the wrong order and an access between the two key writes. When ignored, erase-go reads 0, no stall occurs and the memory is unchanged.
- R7: An armed control write with erase-go, write-enable, erase-select and program-select set (0x8E) raises `cpu_ignore` for two cycles. `cpu_stall` then stays high for exactly ERASE_CYC cycles. Afterwards all 2^BLOCK_W words of the addressed block read all ones, other blocks keep their contents, and erase-go reads 0.
- R8: The erase block is chosen by address bits above BLOCK_W. Bits BLOCK_W-1:0 have no effect.
- R9: An armed erase-go with write-enable clear erases nothing, raises no stall and sets write-error (bit 4).
- R10: One armed control write uses up the unlock. A later erase-go without a fresh key pair is ignored.
- R11: Register writes presented while `cpu_ignore` or `cpu_stall` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (counts as an access for the key logic) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register at `bus_addr` |
| cpu_ignore | output | 1 | Current instruction slot must be discarded |
| cpu_stall | output | 1 | Processor must halt (erase in progress) |

## Verification
The bench builds the block with DEPTH=128, DATA_W=14, BLOCK_W=5 and ERASE_CYC=40. With these values the whole array is only four blocks, so every word can be swept through the read path before and after erases, and any stray write outside the target block shows up. The short erase time makes it practical to count the stall cycles one by one. The 14-bit word exercises zero extension in the high data byte.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam logic [2:0] REG_ADR_LO = 3'd0;
  localparam logic [2:0] REG_ADR_HI = 3'd1;
  localparam logic [2:0] REG_DAT_LO = 3'd2;
  localparam logic [2:0] REG_DAT_HI = 3'd3;
  localparam logic [2:0] REG_CTRL   = 3'd4;
  localparam logic [2:0] REG_KEY    = 3'd5;

  localparam int B_RD   = 0;
  localparam int B_WR   = 1;
  localparam int B_WEN  = 2;
  localparam int B_ERS  = 3;
  localparam int B_ERR  = 4;
  localparam int B_PROG = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_RD1, SQ_RD2, SQ_ES1, SQ_ES2, SQ_ERASE
  } seq_state_t;

  typedef enum logic [1:0] {
    KY_IDLE, KY_HALF, KY_ARMED
  } key_state_t;
endpackage

// File: rtl/fsp_key_gate.sv
module fsp_key_gate
  import fsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_we,
  input  logic [7:0] key_data,
  input  logic       other_acc,
  output logic       armed
);
  key_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= KY_IDLE;
    end else if (key_we) begin
      if (key_data == KEY_FIRST)                       st <= KY_HALF;
      else if (key_data == KEY_SECOND && st == KY_HALF) st <= KY_ARMED;
      else                                             st <= KY_IDLE;
    end else if (other_acc) begin
      st <= KY_IDLE;
    end
  end

  assign armed = (st == KY_ARMED);

  // R5: arming only follows a second-key write made from the half state
  a_r5_arm_after_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(key_we && key_data == KEY_SECOND && st == KY_HALF));
endmodule

// File: rtl/fsp_seq.sv
module fsp_seq
  import fsp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_start,
  input  logic er_start,
  input  logic arr_done,
  output logic ignore,
  output logic stall,
  output logic arr_rd_en,
  output logic arr_er_req,
  output logic rd_done,
  output logic er_done
);
  seq_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      SQ_IDLE:  if (er_start) st_nx = SQ_ES1; else if (rd_start) st_nx = SQ_RD1;
      SQ_RD1:   st_nx = SQ_RD2;
      SQ_RD2:   st_nx = SQ_IDLE;
      SQ_ES1:   st_nx = SQ_ES2;
      SQ_ES2:   st_nx = SQ_ERASE;
      SQ_ERASE: if (arr_done) st_nx = SQ_IDLE;
      default:  st_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SQ_IDLE;
    else     st <= st_nx;
  end

  assign ignore     = (st == SQ_RD1) || (st == SQ_RD2) || (st == SQ_ES1) || (st == SQ_ES2);
  assign stall      = (st == SQ_ERASE);
  assign arr_rd_en  = (st == SQ_RD1);
  assign arr_er_req = (st == SQ_ES2);
  assign rd_done    = (st == SQ_RD2);
  assign er_done    = (st == SQ_ERASE) && arr_done;

  // R2: an ignore window is two cycles long
  a_r2_ignore_two: assert property (@(posedge clk) disable iff (rst)
    $rose(ignore) |=> ignore);
  a_r2_ignore_ends: assert property (@(posedge clk) disable iff (rst)
    (ignore && $past(ignore)) |=> !ignore);
  // R7: a stall is always preceded by the setup slots
  a_r7_stall_after_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> $past(ignore));
endmodule

// File: rtl/fsp_array.sv
module fsp_array #(
  parameter int DEPTH     = 2048,
  parameter int DATA_W    = 14,
  parameter int BLOCK_W   = 5,
  parameter int ERASE_CYC = 64000,
  localparam int AW  = $clog2(DEPTH),
  localparam int BKW = AW - BLOCK_W,
  localparam int CW  = $clog2(ERASE_CYC + 1)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              er_req,
  input  logic [BKW-1:0]    er_block,
  output logic              busy,
  output logic              done
);
  localparam int BLOCK_WORDS = 1 << BLOCK_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     cnt;
  logic [BKW-1:0]    blk_q;
  logic              wr_en;
  logic [AW-1:0]     waddr;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(i * 29 + 7);
  end

  assign wr_en = busy && (cnt < CW'(BLOCK_WORDS));
  assign waddr = {blk_q, cnt[BLOCK_W-1:0]};
  assign done  = busy && (cnt == CW'(ERASE_CYC - 1));

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= '1;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      blk_q <= '0;
    end else if (er_req && !busy) begin
      busy  <= 1'b1;
      cnt   <= '0;
      blk_q <= er_block;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  // R7: a new erase only arrives while the array is idle
  a_r7_req_idle: assert property (@(posedge clk) disable iff (rst)
    er_req |-> !busy);
  a_r7_done_ends: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/flash_selfprog.sv
module flash_selfprog
  import fsp_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int DATA_W    = 14,
  parameter int BLOCK_W   = 5,
  parameter int ERASE_CYC = 64000
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cpu_ignore,
  output logic       cpu_stall
);
  localparam int AW  = $clog2(DEPTH);
  localparam int BKW = AW - BLOCK_W;

  logic [7:0] adr_lo, adr_hi, dat_lo, dat_hi;
  logic c_rd, c_wr, c_wen, c_ers, c_err, c_prog;
  logic acc_we, acc_re, key_we, other_acc, ctl_we, armed;
  logic wr_try, erase_ok, wr_fault, rd_try;
  logic arr_rd_en, arr_er_req, arr_busy, arr_done, rd_done, er_done;
  logic [AW-1:0]     word_addr;
  logic [BKW-1:0]    blk_sel;
  logic [DATA_W-1:0] arr_q;
  logic [15:0]       arr_q16;

  // bus accesses landing in an ignored or stalled slot are dropped
  assign acc_we    = bus_we && !cpu_ignore && !cpu_stall;
  assign acc_re    = bus_re && !cpu_ignore && !cpu_stall;
  assign key_we    = acc_we && (bus_addr == REG_KEY);
  assign other_acc = (acc_we && (bus_addr != REG_KEY)) || acc_re;
  assign ctl_we    = acc_we && (bus_addr == REG_CTRL);

  assign wr_try   = ctl_we && bus_wdata[B_WR] && armed;
  assign erase_ok = wr_try && bus_wdata[B_WEN] && bus_wdata[B_ERS] && bus_wdata[B_PROG];
  assign wr_fault = wr_try && !bus_wdata[B_WEN];
  assign rd_try   = ctl_we && bus_wdata[B_RD] && bus_wdata[B_PROG] && !bus_wdata[B_WR];

  assign word_addr = AW'({adr_hi, adr_lo});
  assign blk_sel   = word_addr[AW-1:BLOCK_W];
  assign arr_q16   = 16'(arr_q);

  fsp_key_gate u_key (
    .clk(clk), .rst(rst), .key_we(key_we), .key_data(bus_wdata),
    .other_acc(other_acc), .armed(armed)
  );

  fsp_seq u_seq (
    .clk(clk), .rst(rst), .rd_start(rd_try), .er_start(erase_ok),
    .arr_done(arr_done), .ignore(cpu_ignore), .stall(cpu_stall),
    .arr_rd_en(arr_rd_en), .arr_er_req(arr_er_req),
    .rd_done(rd_done), .er_done(er_done)
  );

  fsp_array #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .BLOCK_W(BLOCK_W), .ERASE_CYC(ERASE_CYC)
  ) u_arr (
    .clk(clk), .rst(rst), .rd_en(arr_rd_en), .rd_addr(word_addr),
    .rd_data(arr_q), .er_req(arr_er_req), .er_block(blk_sel),
    .busy(arr_busy), .done(arr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_lo <= '0;
      adr_hi <= '0;
    end else if (acc_we) begin
      if (bus_addr == REG_ADR_LO) adr_lo <= bus_wdata;
      if (bus_addr == REG_ADR_HI) adr_hi <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_lo <= '0;
      dat_hi <= '0;
    end else if (rd_done) begin
      dat_lo <= arr_q16[7:0];
      dat_hi <= arr_q16[15:8];
    end else if (acc_we) begin
      if (bus_addr == REG_DAT_LO) dat_lo <= bus_wdata;
      if (bus_addr == REG_DAT_HI) dat_hi <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_rd <= 1'b0; c_wr <= 1'b0; c_wen <= 1'b0;
      c_ers <= 1'b0; c_err <= 1'b0; c_prog <= 1'b0;
    end else if (ctl_we) begin
      c_wen  <= bus_wdata[B_WEN];
      c_ers  <= bus_wdata[B_ERS];
      c_prog <= bus_wdata[B_PROG];
      c_err  <= bus_wdata[B_ERR] || wr_fault;
      c_rd   <= rd_try;
      c_wr   <= erase_ok;
    end else begin
      if (rd_done) c_rd <= 1'b0;
      if (er_done) c_wr <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      REG_ADR_LO: bus_rdata = adr_lo;
      REG_ADR_HI: bus_rdata = adr_hi;
      REG_DAT_LO: bus_rdata = dat_lo;
      REG_DAT_HI: bus_rdata = dat_hi;
      REG_CTRL:   bus_rdata = {c_prog, 2'b00, c_err, c_ers, c_wen, c_wr, c_rd};
      default:    bus_rdata = 8'h00;
    endcase
  end

  // R7: the processor halt coincides with the array being busy
  a_r7_stall_tracks_array: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> arr_busy);
  // R3: data low only moves on a finished read or a direct write
  a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_done && !(acc_we && bus_addr == REG_DAT_LO)) |=> $stable(dat_lo));
  // R6: erase-go only rises when the key logic was armed
  a_r6_go_needs_key: assert property (@(posedge clk) disable iff (rst)
    $rose(c_wr) |-> $past(armed));
  // R9: a write-error never comes with a started sequence
  a_r9_err_no_seq: assert property (@(posedge clk) disable iff (rst)
    ($rose(c_err) && !$past(ctl_we && bus_wdata[B_ERR])) |-> (!cpu_ignore && !cpu_stall));
endmodule

// File: tb/sim_flash_selfprog.sv
module sim_flash_selfprog;
  localparam int DEPTH = 128;
  localparam int DW    = 14;
  localparam int BW    = 5;
  localparam int EC    = 40;
  localparam int MASK  = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic cpu_ignore, cpu_stall;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int exp_mem [DEPTH];

  always #4 clk = ~clk;

  flash_selfprog #(.DEPTH(DEPTH), .DATA_W(DW), .BLOCK_W(BW), .ERASE_CYC(EC)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_ignore(cpu_ignore), .cpu_stall(cpu_stall)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(int a, int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic brd(int a, output int v);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = 3'(a);
    #1 v = int'(bus_rdata);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic set_addr(int a);
    bwr(0, a & 255);
    bwr(1, (a >> 8) & 255);
  endtask

  task automatic read_word(int a, string tag);
    int lo, hi, c;
    set_addr(a);
    bwr(4, 8'h81);
    chk({tag, " R2 ignore slot1"}, int'(cpu_ignore), 1);
    @(negedge clk);
    chk({tag, " R2 ignore slot2"}, int'(cpu_ignore), 1);
    @(negedge clk);
    chk({tag, " R2 ignore off"}, int'(cpu_ignore), 0);
    brd(2, lo);
    brd(3, hi);
    chk({tag, " R2 word"}, hi * 256 + lo, exp_mem[a % DEPTH]);
    brd(4, c);
    chk({tag, " R2 read-go cleared"}, c, 8'h80);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < DEPTH; i++) read_word(i, tag);
  endtask

  task automatic quiet_window(string tag);
    int s;
    s = 0;
    for (int k = 0; k < 6; k++) begin
      if (cpu_ignore || cpu_stall) s++;
      @(negedge clk);
    end
    chk(tag, s, 0);
  endtask

  task automatic erase_at(int a, int gap, string tag);
    int s, c;
    set_addr(a);
    bwr(5, 8'h55);
    repeat (gap) @(negedge clk);
    bwr(5, 8'hAA);
    bwr(4, 8'h8E);
    chk({tag, " R7 setup1 ignore"}, int'(cpu_ignore), 1);
    chk({tag, " R7 setup1 no stall"}, int'(cpu_stall), 0);
    @(negedge clk);
    chk({tag, " R7 setup2 ignore"}, int'(cpu_ignore), 1);
    s = 0;
    for (int k = 0; k <= EC; k++) begin
      @(negedge clk);
      if (cpu_stall) s++;
    end
    chk({tag, " R7 stall length"}, s, EC);
    chk({tag, " R7 stall released"}, int'(cpu_stall), 0);
    for (int i = 0; i < (1 << BW); i++)
      exp_mem[(((a % DEPTH) >> BW) << BW) + i] = MASK;
    brd(4, c);
    chk({tag, " R7 erase-go cleared"}, c, 8'h8C);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, c, lo, hi;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = (i * 29 + 7) & MASK;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int r = 0; r < 8; r++) begin
      brd(r, v);
      chk($sformatf("R1 reg %0d", r), v, 0);
    end
    chk("R1 ignore low", int'(cpu_ignore), 0);
    chk("R1 stall low", int'(cpu_stall), 0);

    // R2: full read sweep of the power-up pattern
    sweep("initial");

    // R3: processor writes to data registers stick and hold
    bwr(2, 8'h5A);
    bwr(3, 8'hC3);
    set_addr(12);
    bwr(5, 8'h13);
    brd(2, lo);
    brd(3, hi);
    chk("R3 data lo held", lo, 8'h5A);
    chk("R3 data hi held", hi, 8'hC3);

    // R4: read-go with program-select clear does nothing
    bwr(4, 8'h01);
    chk("R4 no ignore", int'(cpu_ignore), 0);
    @(negedge clk);
    chk("R4 no ignore later", int'(cpu_ignore), 0);
    brd(4, c);
    chk("R4 read-go stays 0", c, 0);
    brd(2, lo);
    chk("R4 data unchanged", lo, 8'h5A);

    // R11: a write in an ignored slot is dropped
    set_addr(9);
    bwr(4, 8'h81);
    bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'hFF;
    @(negedge clk);
    bus_we = 1'b0;
    @(negedge clk);
    brd(0, v);
    chk("R11 address kept", v, 9);
    brd(2, lo);
    brd(3, hi);
    chk("R11 read used old address", hi * 256 + lo, exp_mem[9]);

    // R7, R8: erase block 2 using an address with low bits set
    erase_at(8'h45, 0, "blk2");
    // R11: a write during the stall is dropped
    set_addr(8'h30);
    bwr(5, 8'h55); bwr(5, 8'hAA); bwr(4, 8'h8E);
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h11;
    @(negedge clk);
    bus_we = 1'b0;
    wait (!cpu_stall);
    @(negedge clk);
    brd(0, v);
    chk("R11 write during stall dropped", v, 8'h30);
    for (int i = 32; i < 64; i++) exp_mem[i] = MASK;
    sweep("after blk2 blk1");

    // R10: unlock is used up
    bwr(4, 8'h8E);
    quiet_window("R10 no second erase");
    brd(4, c);
    chk("R10 erase-go 0", c, 8'h8C);

    // R6: wrong order
    set_addr(0);
    bwr(5, 8'hAA); bwr(5, 8'h55); bwr(4, 8'h8E);
    quiet_window("R6 wrong order");
    brd(4, c);
    chk("R6 wrong order go 0", c, 8'h8C);
    // R6: access between key writes
    bwr(5, 8'h55); brd(0, v); bwr(5, 8'hAA); bwr(4, 8'h8E);
    quiet_window("R6 access between");
    // R6: wrong second value
    bwr(5, 8'h55); bwr(5, 8'hAB); bwr(4, 8'h8E);
    quiet_window("R6 wrong value");

    // R9: no write-enable sets the error bit
    bwr(5, 8'h55); bwr(5, 8'hAA); bwr(4, 8'h8A);
    quiet_window("R9 no stall");
    brd(4, c);
    chk("R9 error set", c, 8'h98);

    // R5: idle cycles between key writes are allowed (block 3)
    erase_at(8'h7F, 3, "R5 blk3");

    // R6, R8, R9: block 0 survived, blocks 1..3 erased
    sweep("final");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule